// File: doc/BRIEF.md
# Free-Running Timer with Output Compare Channels

The block is a 16-bit up-counter that advances at a selectable fraction of the system clock, with five compare channels watching it. Each channel holds a 16-bit target. When the counter steps onto a channel's target, the channel raises its status flag and applies its configured action to its own output pin: disconnect, toggle, drive low or drive high. Software may also trigger a channel's action directly with a force strobe, without any match taking place.

A simple synchronous register port gives software access to the block. Writes take effect at the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. The register map is listed below; addresses depend on the channel count `NCH`, which may be at most 8.

- 0x0 holds the counter and is read-only.
- 0x1 to 0x5 hold the channel compare values (channel i at address 1+i).
- 0x6 holds the action codes.
- 0x7 holds the interrupt masks.
- 0x8 holds the flags.
- 0x9 holds the divider select.
- 0xA is the force strobe.

A single interrupt line combines every enabled flag.

Top module: `oc_timer`

## Requirements
- R1: After reset the counter reads 0, all flags, masks, action codes and pins are 0, and `irq` is low. A write to address 0x0 has no effect: the counter only advances by 1 per divider step.
- R2: The divider select is bits 1:0 of address 0x9. Code 00 makes the counter step every clock, 01 every 4 clocks, 10 every 8 clocks and 11 every 16 clocks. An accepted write restarts the division, so the first step comes N clocks after the write edge.
- R3: The divider select accepts only one write. That write must fall on one of the first 64 clock edges after reset is released. Any later write leaves the readback and the step rate unchanged.
- R4: When the counter steps from 0xFFFF to 0x0000, flag bit 5 of address 0x8 sets. `irq` rises if enable bit 5 of address 0x7 is set.
- R5: Writing 1 to a flag bit at 0x8 clears it. Writing 0 leaves it unchanged.
- R6: On every counter step that lands on a channel's compare value, that channel's flag bit i at 0x8 sets, on the same edge as the step. This repeats after each wrap.
- R7: `irq` is high exactly while some flag bit and its mask bit at 0x7 (bit i for channel i, bit 5 for overflow) are both set.
- R8: Writing 1 to bit i of 0xA applies channel i's action on that edge. It does not set the channel's flag, and the address always reads 0.
- R9: Action code for channel i is bits 2i+1:2i of 0x6. Code 00 holds the pin and drives `cmp_oe[i]` low. Code 01 toggles the pin, 10 drives it low and 11 drives it high. The action happens on the same edge as the flag sets.
- R10: A compare value is loaded whole from one 16-bit write and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, acts at the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt request |
| cmp_out | output | 5 | Channel output pin values |
| cmp_oe | output | 5 | Channel pin drive enables (action code not 00) |

## Verification
Every result lands on the edge that causes it: the counter step, the compare flag, the pin action, the overflow flag, flag clears and forced actions all appear one register stage after their cause, and `irq` follows the flags combinationally. The bench drives inputs just after a falling edge and reads back in the next low phase, so each read sees exactly the edges that have passed. Counter-based expectations are computed as a start value plus the floor of elapsed edges over the divide ratio. Compare waits poll the counter each cycle and check the flag both one step before the target (still clear) and at the target (set).

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  // terminal value of the divider counter for a select code
  function automatic logic [3:0] div_last(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd0;
      2'b01:   return 4'd3;
      2'b10:   return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

  // new pin value after an action
  function automatic logic pin_after(input act_e a, input logic cur);
    case (a)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/oc_timer_base.sv
module oc_timer_base
  import oc_timer_pkg::*;
#(
  parameter int CW     = 16,
  parameter int WINDOW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psc_we,
  input  logic [1:0]    psc_wdata,
  output logic [1:0]    psc_sel,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next,
  output logic          step,
  output logic          wrap
);
  localparam int AGE_W = $clog2(WINDOW + 1);

  logic [3:0]       div_cnt;
  logic [AGE_W-1:0] age;
  logic             locked;
  logic             psc_accept;

  assign step       = (div_cnt == div_last(psc_sel));
  assign count_next = count + 1'b1;
  assign wrap       = step && (count == {CW{1'b1}});
  assign psc_accept = psc_we && !locked && (age < AGE_W'(WINDOW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      age     <= '0;
      locked  <= 1'b0;
      psc_sel <= 2'b00;
      count   <= '0;
    end else begin
      if (age < AGE_W'(WINDOW)) age <= age + 1'b1;
      if (psc_accept) begin
        psc_sel <= psc_wdata;
        locked  <= 1'b1;
        div_cnt <= '0;
      end else if (step) begin
        div_cnt <= '0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (step) count <= count_next;
    end
  end

  // R1: counter advances by exactly one per step
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == $past(count) + 1'b1);
  // R2: without a step the counter holds
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));
  // R3: once locked the divider select never changes
  a_r3_psc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(psc_sel));

endmodule

// File: rtl/oc_timer_chan.sv
module oc_timer_chan
  import oc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          act_we,
  input  logic [1:0]    act_wdata,
  input  logic          msk_we,
  input  logic          msk_wdata,
  input  logic          flag_clr,
  input  logic          force_i,
  input  logic          step_i,
  input  logic [CW-1:0] count_next_i,
  output logic [CW-1:0] cmp_val,
  output logic [1:0]    act_val,
  output logic          msk,
  output logic          flag,
  output logic          pin,
  output logic          oe,
  output logic          match_o
);
  act_e act_q;

  assign match_o = step_i && (count_next_i == cmp_val);
  assign act_val = act_q;
  assign oe      = (act_q != ACT_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '0;
      act_q   <= ACT_OFF;
      msk     <= 1'b0;
      flag    <= 1'b0;
      pin     <= 1'b0;
    end else begin
      if (cmp_we) cmp_val <= cmp_wdata;
      if (act_we) act_q   <= act_e'(act_wdata);
      if (msk_we) msk     <= msk_wdata;
      if (match_o)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (match_o || force_i) pin <= pin_after(act_q, pin);
    end
  end

  // R6: a match always leaves the flag set
  a_r6_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> flag);
  // R8: a forced action alone never raises the flag
  a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && !match_o && !flag) |=> !flag);
  // R9: toggle action flips the pin
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && act_q == ACT_TOGGLE) |=> pin != $past(pin));
  // R9: disconnected channel holds its pin
  a_r9_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == ACT_OFF) |=> $stable(pin));

endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CW     = 16,
  parameter int WINDOW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     reg_addr,
  input  logic           reg_wr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  output logic           irq,
  output logic [NCH-1:0] cmp_out,
  output logic [NCH-1:0] cmp_oe
);
  localparam logic [3:0] A_CNT = 4'd0;
  localparam logic [3:0] A_ACT = 4'(NCH + 1);
  localparam logic [3:0] A_MSK = 4'(NCH + 2);
  localparam logic [3:0] A_FLG = 4'(NCH + 3);
  localparam logic [3:0] A_PSC = 4'(NCH + 4);
  localparam logic [3:0] A_FRC = 4'(NCH + 5);

  logic [CW-1:0]  count, count_next;
  logic           step, wrap;
  logic [1:0]     psc_sel;
  logic [CW-1:0]  cmp_val [NCH];
  logic [1:0]     act_val [NCH];
  logic [NCH-1:0] msk, flag, match;
  logic           ovf_en, ovf_flag;
  logic           wr_msk, wr_flg;

  assign wr_msk = reg_wr && (reg_addr == A_MSK);
  assign wr_flg = reg_wr && (reg_addr == A_FLG);

  oc_timer_base #(.CW(CW), .WINDOW(WINDOW)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .psc_we     (reg_wr && (reg_addr == A_PSC)),
    .psc_wdata  (reg_wdata[1:0]),
    .psc_sel    (psc_sel),
    .count      (count),
    .count_next (count_next),
    .step       (step),
    .wrap       (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oc_timer_chan #(.CW(CW)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmp_we       (reg_wr && (reg_addr == 4'(i + 1))),
      .cmp_wdata    (reg_wdata),
      .act_we       (reg_wr && (reg_addr == A_ACT)),
      .act_wdata    (reg_wdata[2*i +: 2]),
      .msk_we       (wr_msk),
      .msk_wdata    (reg_wdata[i]),
      .flag_clr     (wr_flg && reg_wdata[i]),
      .force_i      (reg_wr && (reg_addr == A_FRC) && reg_wdata[i]),
      .step_i       (step),
      .count_next_i (count_next),
      .cmp_val      (cmp_val[i]),
      .act_val      (act_val[i]),
      .msk          (msk[i]),
      .flag         (flag[i]),
      .pin          (cmp_out[i]),
      .oe           (cmp_oe[i]),
      .match_o      (match[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_en   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_msk) ovf_en <= reg_wdata[NCH];
      if (wrap)                           ovf_flag <= 1'b1;
      else if (wr_flg && reg_wdata[NCH])  ovf_flag <= 1'b0;
    end
  end

  assign irq = (ovf_flag && ovf_en) || |(flag & msk);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT: reg_rdata = count;
      A_MSK: reg_rdata[NCH:0] = {ovf_en, msk};
      A_FLG: reg_rdata[NCH:0] = {ovf_flag, flag};
      A_PSC: reg_rdata[1:0] = psc_sel;
      A_ACT: for (int i = 0; i < NCH; i++) reg_rdata[2*i +: 2] = act_val[i];
      default: begin
        for (int i = 0; i < NCH; i++)
          if (reg_addr == 4'(i + 1)) reg_rdata = cmp_val[i];
      end
    endcase
  end

  // R4: a wrap leaves the overflow flag set
  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R7: interrupt only with an enabled flag
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag || (|flag)));

endmodule

// File: tb/test_oc_timer.sv
module test_oc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic [4:0]  cmp_out, cmp_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  oc_timer i_oc_timer (.*);

  // {divider code, edges waited, expected counter advance}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'd48, 8'd48}, {2'd1, 8'd48, 8'd12}, {2'd2, 8'd48, 8'd6},
    {2'd3, 8'd48, 8'd3},  {2'd2, 8'd20, 8'd2},  {2'd3, 8'd15, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] c0, c1, v, t, f;
    // R1 reset state
    do_reset();
    rd_reg(4'h0, v); chk("R1 count at reset", v, 0);
    rd_reg(4'h8, v); chk("R1 flags at reset", v, 0);
    chk("R1 irq at reset", irq, 0);
    chk("R1 oe at reset", cmp_oe, 0);
    chk("R1 pins at reset", cmp_out, 0);

    // R2 divider table
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr_reg(4'h9, {14'd0, VEC[k][17:16]});
      rd_reg(4'h9, v); chk("R2 divider readback", v, {14'd0, VEC[k][17:16]});
      rd_reg(4'h0, c0);
      repeat (int'(VEC[k][15:8])) @(negedge clk);
      rd_reg(4'h0, c1);
      chk("R2 counter advance", c1 - c0, {8'd0, VEC[k][7:0]});
    end

    // R3 late write ignored
    do_reset();
    repeat (70) @(negedge clk);
    wr_reg(4'h9, 16'd3);
    rd_reg(4'h9, v); chk("R3 late divider write", v, 0);
    rd_reg(4'h0, c0);
    repeat (16) @(negedge clk);
    rd_reg(4'h0, c1); chk("R3 rate unchanged", c1 - c0, 16);

    // R3 second write ignored
    do_reset();
    wr_reg(4'h9, 16'd1);
    wr_reg(4'h9, 16'd3);
    rd_reg(4'h9, v); chk("R3 write once", v, 1);

    // main function at divide 1
    do_reset();
    rd_reg(4'h0, c0);
    wr_reg(4'h0, 16'h1234);
    rd_reg(4'h0, c1); chk("R1 counter not writable", c1, c0 + 16'd2);

    wr_reg(4'h5, 16'hA5C3);
    rd_reg(4'h5, v); chk("R10 compare readback", v, 16'hA5C3);

    rd_reg(4'h0, v);
    t = v + 16'd40;
    wr_reg(4'h1, t);
    wr_reg(4'h3, t);
    wr_reg(4'h6, 16'b00_01_00_11); // ch0 high, ch2 toggle
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      rd_reg(4'h0, v);
      if (v == t - 16'd1) begin
        rd_reg(4'h8, f); chk("R6 flag clear before match", f[0], 0);
      end
      if (v == t) begin
        rd_reg(4'h8, f);
        chk("R6 flags on match", {f[2], f[0]}, 2'b11);
        chk("R9 high action", cmp_out[0], 1);
        chk("R9 toggle action", cmp_out[2], 1);
        chk("R9 oe on", cmp_oe, 5'b00101);
        break;
      end
    end
    chk("R7 irq masked", irq, 0);
    wr_reg(4'h7, 16'h0001);
    chk("R7 irq enabled", irq, 1);
    wr_reg(4'h8, 16'h0000);
    rd_reg(4'h8, f); chk("R5 write 0 keeps", f[2:0], 3'b101);
    wr_reg(4'h8, 16'h0001);
    rd_reg(4'h8, f); chk("R5 write 1 clears", f[2:0], 3'b100);
    chk("R7 irq drops", irq, 0);
    wr_reg(4'h8, 16'h0004);

    // R4 wrap, R6 repeat match
    wr_reg(4'h7, 16'h0020);
    wr_reg(4'h6, 16'b00_01_00_10); // ch0 low, ch2 toggle
    for (int n = 0; n < 70000; n++) begin
      @(negedge clk);
      rd_reg(4'h0, v);
      if (v == 16'hFFFF) begin
        rd_reg(4'h8, f); chk("R4 no overflow yet", f[5], 0);
      end
      if (v == 16'h0000) begin
        rd_reg(4'h8, f); chk("R4 overflow flag", f[5], 1);
        chk("R4 overflow irq", irq, 1);
        break;
      end
    end
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      rd_reg(4'h0, v);
      if (v == t) begin
        rd_reg(4'h8, f); chk("R6 repeat match", {f[2], f[0]}, 2'b11);
        chk("R9 low action", cmp_out[0], 0);
        chk("R9 toggle back", cmp_out[2], 0);
        break;
      end
    end

    // R8 force
    wr_reg(4'h6, 16'b00_00_01_00); // ch1 toggle only
    wr_reg(4'h8, 16'h003F);
    wr_reg(4'hA, 16'h0002);
    chk("R8 force toggles", cmp_out[1], 1);
    rd_reg(4'h8, f); chk("R8 force leaves flag", f[1], 0);
    rd_reg(4'hA, v); chk("R8 force reads 0", v, 0);
    wr_reg(4'hA, 16'h0002);
    chk("R8 force toggles back", cmp_out[1], 0);
    wr_reg(4'h6, 16'b00_00_11_00);
    wr_reg(4'hA, 16'h0002);
    chk("R8 force high", cmp_out[1], 1);
    wr_reg(4'h6, 16'h0000);
    wr_reg(4'hA, 16'h0002);
    chk("R9 off holds pin", cmp_out[1], 1);
    chk("R9 off oe low", cmp_oe[1], 0);

    done = 1;
    summary();
    $finish;
  end
endmodule